// File: doc/BRIEF.md
# Shift, Extend and Align Unit

This unit is a helper stage for a 32-bit RISC datapath. It puts three jobs behind one operation select: a barrel shifter (logical left, logical right, arithmetic right), widening of immediate fields from an instruction word, and alignment of memory data for byte, halfword and word transfers. Memory is big-endian, so the byte at offset 0 sits in bits 31:24 of a word.

For a load, the operand is the word read from memory. The unit picks the lane that the low address bits name and widens it with sign or zeros. For a store, the operand holds the register value. The unit copies the byte or halfword into every lane and produces a byte-enable in big-endian lane order. A sub-word access at an address that does not suit its size raises a misalignment flag.

All results pass through one register stage. A valid input gives a valid output one cycle later.

Top module: `sxa_unit`

## Requirements
- R1: With op 0 (shift left logical), result = operand shifted left by shamt (0..31), with zeros filling from the right.
- R2: With op 1 (shift right logical), result = operand shifted right by shamt, with zeros filling from the left; a shamt of 0 returns the operand unchanged.
- R3: With op 2 (shift right arithmetic), result = operand shifted right by shamt, with copies of operand bit 31 filling from the left.
- R4: With op 3 the low 16 bits of operand are sign-extended to 32 bits; with op 4 they are zero-extended.
- R5: With op 5 the low 26 bits of operand are sign-extended from bit 25 to 32 bits.
- R6: Loads are op 6 (sign-extending) and op 7 (zero-extending). A byte load (size 0) takes the byte at offset addr_lo, where offset 0 = bits 31:24, offset 1 = bits 23:16, offset 2 = bits 15:8 and offset 3 = bits 7:0, and extends it to 32 bits.
- R7: A halfword load (size 1) takes bits 31:16 when addr_lo[1]=0 and bits 15:0 when addr_lo[1]=1, then extends them. A word load (size 2 or 3) returns the operand unchanged.
- R8: A store (op 8) copies operand[7:0] into all four lanes for size 0, copies operand[15:0] into both halves for size 1, and passes the operand through for size 2 or 3. byte_en bit 3 stands for offset 0 (bits 31:24) and bit 0 for offset 3, so a byte store gives one bit set at position 3-addr_lo, a halfword store gives 4'b1100 or 4'b0011, and a word store gives 4'b1111. Every other op gives byte_en = 0.
- R9: For ops 6, 7 and 8, misalign is 1 for a halfword with addr_lo[0]=1 and for a word with addr_lo≠0. Every other op gives misalign 0 whatever the address. A misaligned store forces byte_en to 0 but still delivers the replicated data. A misaligned load still delivers the lane chosen by the rules above.
- R10: out_valid is in_valid delayed by one clock. When in_valid is 0 the registered result, byte_en and misalign keep their values.
- R11: While rst_n is low, out_valid, result, byte_en and misalign are all 0. Reset takes effect at once and is released on the clock.
- R12: Op codes 9 to 15 give result 0, byte_en 0 and misalign 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| in_valid | input | 1 | Input qualifier and register enable |
| op | input | 4 | Operation select (codes per requirements) |
| operand | input | 32 | Data word, immediate source or memory word |
| shamt | input | 5 | Shift amount |
| addr_lo | input | 2 | Byte offset within the word |
| size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| out_valid | output | 1 | Result qualifier |
| result | output | 32 | Registered result |
| byte_en | output | 4 | Store lane enables, bit 3 = offset 0 |
| misalign | output | 1 | Access address does not suit its size |

## Verification
Lane alignment and the misalignment check act in the same cycle on every load and store. A misaligned access therefore has to produce both a defined data word and a correct flag. The bench drives halfword and word accesses at odd or unaligned offsets, including a halfword load whose chosen lane has its sign bit set. For loads it checks that the extended lane is still correct and the flag is raised. For stores it checks that the replicated data appears while byte_en is forced to zero. It also drives shift ops with a nonzero address and an unaligned size, to show that the alignment check stays silent for shifts.

// File: rtl/sxa_pkg.sv
package sxa_pkg;

  typedef enum logic [3:0] {
    SXA_SLL    = 4'd0,
    SXA_SRL    = 4'd1,
    SXA_SRA    = 4'd2,
    SXA_IMM16S = 4'd3,
    SXA_IMM16U = 4'd4,
    SXA_IMM26S = 4'd5,
    SXA_LDS    = 4'd6,
    SXA_LDU    = 4'd7,
    SXA_ST     = 4'd8
  } sxa_op_e;

  localparam logic [1:0] SXA_SZ_BYTE = 2'd0;
  localparam logic [1:0] SXA_SZ_HALF = 2'd1;

endpackage

// File: rtl/sxa_shifter.sv
module sxa_shifter #(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SH_W-1:0]   shamt,
  input  logic              go_right,
  input  logic              arith,
  output logic [DATA_W-1:0] dout
);

  logic              fill;
  logic [DATA_W-1:0] lv;
  logic [DATA_W-1:0] rv;

  assign fill = arith & din[DATA_W-1];

  // log-depth stages: stage i moves by 2**i positions
  always_comb begin
    lv = din;
    rv = din;
    for (int i = 0; i < SH_W; i++) begin
      if (shamt[i]) begin
        lv = lv << (1 << i);
        rv = (rv >> (1 << i)) |
             (fill ? ~({DATA_W{1'b1}} >> (1 << i)) : {DATA_W{1'b0}});
      end
    end
    dout = go_right ? rv : lv;
  end

endmodule

// File: rtl/sxa_immext.sv
module sxa_immext #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int JMP_W  = 26
) (
  input  logic [DATA_W-1:0] din,
  input  logic              wide,
  input  logic              sgn,
  output logic [DATA_W-1:0] dout
);

  always_comb begin
    if (wide) begin
      dout = {{(DATA_W-JMP_W){din[JMP_W-1]}}, din[JMP_W-1:0]};
    end else begin
      dout = {{(DATA_W-IMM_W){sgn & din[IMM_W-1]}}, din[IMM_W-1:0]};
    end
  end

endmodule

// File: rtl/sxa_lane.sv
module sxa_lane
  import sxa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int ADDR_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [ADDR_W-1:0] addr_lo,
  input  logic [1:0]        size,
  input  logic              is_load,
  input  logic              ld_sign,
  input  logic              is_store,
  output logic [DATA_W-1:0] ld_data,
  output logic [DATA_W-1:0] st_data,
  output logic [LANES-1:0]  st_be,
  output logic              misalign
);

  localparam int HALVES = LANES / 2;

  logic [7:0]  lane_b [LANES];
  logic [15:0] lane_h [HALVES];
  logic [7:0]  sel_b;
  logic [15:0] sel_h;
  logic        size_b;
  logic        size_h;
  logic        bad_addr;

  // big-endian slicing: lane 0 is the most significant byte
  for (genvar k = 0; k < LANES; k++) begin : g_byte
    assign lane_b[k] = din[DATA_W-1-8*k -: 8];
  end
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign lane_h[h] = din[DATA_W-1-16*h -: 16];
  end

  assign size_b = (size == SXA_SZ_BYTE);
  assign size_h = (size == SXA_SZ_HALF);

  always_comb begin
    sel_b = '0;
    sel_h = '0;
    for (int k = 0; k < LANES; k++) begin
      if (k == int'(addr_lo)) sel_b = lane_b[k];
    end
    for (int h = 0; h < HALVES; h++) begin
      if (h == int'(addr_lo >> 1)) sel_h = lane_h[h];
    end
  end

  always_comb begin
    if (size_b) begin
      ld_data = {{(DATA_W-8){ld_sign & sel_b[7]}}, sel_b};
      st_data = {LANES{din[7:0]}};
    end else if (size_h) begin
      ld_data = {{(DATA_W-16){ld_sign & sel_h[15]}}, sel_h};
      st_data = {HALVES{din[15:0]}};
    end else begin
      ld_data = din;
      st_data = din;
    end
  end

  always_comb begin
    if (size_h) begin
      bad_addr = addr_lo[0];
    end else if (!size_b) begin
      bad_addr = (addr_lo != '0);
    end else begin
      bad_addr = 1'b0;
    end
  end

  assign misalign = (is_load | is_store) & bad_addr;

  always_comb begin
    st_be = '0;
    if (is_store && !bad_addr) begin
      for (int k = 0; k < LANES; k++) begin
        if (size_b) begin
          if (k == int'(addr_lo)) st_be[LANES-1-k] = 1'b1;
        end else if (size_h) begin
          if ((k / 2) == int'(addr_lo >> 1)) st_be[LANES-1-k] = 1'b1;
        end else begin
          st_be[LANES-1-k] = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sxa_unit.sv
module sxa_unit
  import sxa_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W),
  parameter int LANES  = DATA_W / 8,
  parameter int ADDR_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] operand,
  input  logic [SH_W-1:0]   shamt,
  input  logic [ADDR_W-1:0] addr_lo,
  input  logic [1:0]        size,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [LANES-1:0]  byte_en,
  output logic              misalign
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       core_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  // decode
  sxa_op_e op_e;
  logic    is_shift, is_imm, is_load, is_store;

  assign op_e     = sxa_op_e'(op);
  assign is_shift = (op_e == SXA_SLL) || (op_e == SXA_SRL) || (op_e == SXA_SRA);
  assign is_imm   = (op_e == SXA_IMM16S) || (op_e == SXA_IMM16U) || (op_e == SXA_IMM26S);
  assign is_load  = (op_e == SXA_LDS) || (op_e == SXA_LDU);
  assign is_store = (op_e == SXA_ST);

  logic [DATA_W-1:0] sh_out, imm_out, ld_out, st_out;
  logic [LANES-1:0]  st_be;
  logic              lane_mis;

  sxa_shifter #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shift (
    .din      (operand),
    .shamt    (shamt),
    .go_right (op_e != SXA_SLL),
    .arith    (op_e == SXA_SRA),
    .dout     (sh_out)
  );

  sxa_immext #(.DATA_W(DATA_W)) u_imm (
    .din  (operand),
    .wide (op_e == SXA_IMM26S),
    .sgn  (op_e == SXA_IMM16S),
    .dout (imm_out)
  );

  sxa_lane #(.DATA_W(DATA_W), .LANES(LANES), .ADDR_W(ADDR_W)) u_lane (
    .din      (operand),
    .addr_lo  (addr_lo),
    .size     (size),
    .is_load  (is_load),
    .ld_sign  (op_e == SXA_LDS),
    .is_store (is_store),
    .ld_data  (ld_out),
    .st_data  (st_out),
    .st_be    (st_be),
    .misalign (lane_mis)
  );

  // next-state
  logic [DATA_W-1:0] result_d;
  logic [LANES-1:0]  be_d;
  logic              mis_d;

  always_comb begin
    result_d = '0;
    if (is_shift)      result_d = sh_out;
    else if (is_imm)   result_d = imm_out;
    else if (is_load)  result_d = ld_out;
    else if (is_store) result_d = st_out;
    be_d  = st_be;
    mis_d = lane_mis;
  end

  // register stage, enabled by in_valid
  logic              valid_q;
  logic [DATA_W-1:0] result_q;
  logic [LANES-1:0]  be_q;
  logic              mis_q;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      valid_q  <= 1'b0;
      result_q <= '0;
      be_q     <= '0;
      mis_q    <= 1'b0;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        result_q <= result_d;
        be_q     <= be_d;
        mis_q    <= mis_d;
      end
    end
  end

  assign out_valid = valid_q;
  assign result    = result_q;
  assign byte_en   = be_q;
  assign misalign  = mis_q;

  // assertions
  assert_valid_lat_R10: assert property (@(posedge clk) disable iff (!core_rst_n)
    in_valid |=> out_valid);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!core_rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(byte_en) && $stable(misalign)));

  assert_sll_zero_R1: assert property (@(posedge clk) disable iff (!core_rst_n)
    (in_valid && op == 4'd0 && shamt == '0) |=> (result == $past(operand)));

  assert_word_load_R7: assert property (@(posedge clk) disable iff (!core_rst_n)
    (in_valid && (op == 4'd6 || op == 4'd7) && size[1] && addr_lo == '0)
      |=> (result == $past(operand) && !misalign));

  assert_mis_no_be_R9: assert property (@(posedge clk) disable iff (!core_rst_n)
    (out_valid && misalign) |-> (byte_en == '0));

  assert_nonmem_quiet_R9: assert property (@(posedge clk) disable iff (!core_rst_n)
    (in_valid && op != 4'd6 && op != 4'd7 && op != 4'd8)
      |=> (!misalign && byte_en == '0));

  assert_be_shape_R8: assert property (@(posedge clk) disable iff (!core_rst_n)
    (out_valid && byte_en != '0)
      |-> ($countones(byte_en) == 1 || $countones(byte_en) == 2 || $countones(byte_en) == LANES));

endmodule

// File: tb/tb_sxa_unit.sv
`timescale 1ns/1ps
module tb_sxa_unit;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  op;
  logic [31:0] operand;
  logic [4:0]  shamt;
  logic [1:0]  addr_lo;
  logic [1:0]  size;
  logic        out_valid;
  logic [31:0] result;
  logic [3:0]  byte_en;
  logic        misalign;

  sxa_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .operand(operand), .shamt(shamt), .addr_lo(addr_lo), .size(size),
    .out_valid(out_valid), .result(result), .byte_en(byte_en),
    .misalign(misalign)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  // vector: {req4, op4, size2, addr2, shamt5, operand32, result32, be4, mis1}
  localparam int NV = 34;
  localparam logic [85:0] VEC [0:NV-1] = '{
    {4'd1, 4'd0,2'd0,2'd0,5'd4, 32'h87654321,32'h76543210,4'h0,1'b0},
    {4'd1, 4'd0,2'd0,2'd0,5'd31,32'h00000003,32'h80000000,4'h0,1'b0},
    {4'd2, 4'd1,2'd0,2'd0,5'd8, 32'h87654321,32'h00876543,4'h0,1'b0},
    {4'd3, 4'd2,2'd0,2'd0,5'd8, 32'h87654321,32'hFF876543,4'h0,1'b0},
    {4'd3, 4'd2,2'd0,2'd0,5'd31,32'h80000000,32'hFFFFFFFF,4'h0,1'b0},
    {4'd3, 4'd2,2'd0,2'd0,5'd4, 32'h70000000,32'h07000000,4'h0,1'b0},
    {4'd2, 4'd1,2'd0,2'd0,5'd0, 32'hDEADBEEF,32'hDEADBEEF,4'h0,1'b0},
    {4'd4, 4'd3,2'd0,2'd0,5'd0, 32'h12348001,32'hFFFF8001,4'h0,1'b0},
    {4'd4, 4'd4,2'd0,2'd0,5'd0, 32'h12348001,32'h00008001,4'h0,1'b0},
    {4'd4, 4'd3,2'd0,2'd0,5'd0, 32'hFFFF7FFF,32'h00007FFF,4'h0,1'b0},
    {4'd5, 4'd5,2'd0,2'd0,5'd0, 32'h02000000,32'hFE000000,4'h0,1'b0},
    {4'd5, 4'd5,2'd0,2'd0,5'd0, 32'hFDFFFFFF,32'h01FFFFFF,4'h0,1'b0},
    {4'd6, 4'd6,2'd0,2'd0,5'd0, 32'h87654321,32'hFFFFFF87,4'h0,1'b0},
    {4'd6, 4'd7,2'd0,2'd0,5'd0, 32'h87654321,32'h00000087,4'h0,1'b0},
    {4'd6, 4'd6,2'd0,2'd1,5'd0, 32'h87654321,32'h00000065,4'h0,1'b0},
    {4'd6, 4'd6,2'd0,2'd3,5'd0, 32'h87654321,32'h00000021,4'h0,1'b0},
    {4'd6, 4'd6,2'd0,2'd2,5'd0, 32'h0000F000,32'hFFFFFFF0,4'h0,1'b0},
    {4'd7, 4'd6,2'd1,2'd0,5'd0, 32'h87654321,32'hFFFF8765,4'h0,1'b0},
    {4'd7, 4'd7,2'd1,2'd2,5'd0, 32'h8765C321,32'h0000C321,4'h0,1'b0},
    {4'd7, 4'd6,2'd1,2'd2,5'd0, 32'h8765C321,32'hFFFFC321,4'h0,1'b0},
    {4'd7, 4'd6,2'd2,2'd0,5'd0, 32'h87654321,32'h87654321,4'h0,1'b0},
    {4'd9, 4'd6,2'd1,2'd1,5'd0, 32'h87654321,32'hFFFF8765,4'h0,1'b1},
    {4'd9, 4'd7,2'd2,2'd2,5'd0, 32'h87654321,32'h87654321,4'h0,1'b1},
    {4'd8, 4'd8,2'd0,2'd0,5'd0, 32'h000000AB,32'hABABABAB,4'h8,1'b0},
    {4'd8, 4'd8,2'd0,2'd3,5'd0, 32'h000000AB,32'hABABABAB,4'h1,1'b0},
    {4'd8, 4'd8,2'd1,2'd2,5'd0, 32'h1234CDEF,32'hCDEFCDEF,4'h3,1'b0},
    {4'd8, 4'd8,2'd1,2'd0,5'd0, 32'h1234CDEF,32'hCDEFCDEF,4'hC,1'b0},
    {4'd8, 4'd8,2'd2,2'd0,5'd0, 32'h1234CDEF,32'h1234CDEF,4'hF,1'b0},
    {4'd9, 4'd8,2'd1,2'd3,5'd0, 32'h1234CDEF,32'hCDEFCDEF,4'h0,1'b1},
    {4'd9, 4'd8,2'd2,2'd1,5'd0, 32'h1234CDEF,32'h1234CDEF,4'h0,1'b1},
    {4'd12,4'd9,2'd0,2'd0,5'd0, 32'h87654321,32'h00000000,4'h0,1'b0},
    {4'd9, 4'd0,2'd1,2'd1,5'd1, 32'h00000001,32'h00000002,4'h0,1'b0},
    {4'd8, 4'd8,2'd3,2'd0,5'd0, 32'h1234CDEF,32'h1234CDEF,4'hF,1'b0},
    {4'd8, 4'd8,2'd0,2'd1,5'd0, 32'h000000AB,32'hABABABAB,4'h4,1'b0}
  };

  function automatic string req_name(input logic [3:0] idx);
    case (idx)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      4'd10:   return "R10";
      4'd11:   return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_outputs(input string req, input logic v,
                               input logic [31:0] r, input logic [3:0] be,
                               input logic m);
    check(req, "out_valid", {31'd0, out_valid}, {31'd0, v});
    check(req, "result",    result,             r);
    check(req, "byte_en",   {28'd0, byte_en},   {28'd0, be});
    check(req, "misalign",  {31'd0, misalign},  {31'd0, m});
  endtask

  task automatic drive(input logic v, input logic [3:0] o, input logic [1:0] s,
                       input logic [1:0] a, input logic [4:0] sh,
                       input logic [31:0] d);
    in_valid = v; op = o; size = s; addr_lo = a; shamt = sh; operand = d;
  endtask

  initial begin
    #50000;
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b1, 4'd8, 2'd2, 2'd0, 5'd0, 32'hFFFFFFFF);
    repeat (3) @(negedge clk);
    // R11: outputs cleared while reset is held, even with valid input
    check_outputs("R11", 1'b0, 32'h0, 4'h0, 1'b0);
    drive(1'b0, 4'd0, 2'd0, 2'd0, 5'd0, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_outputs("R11", 1'b0, 32'h0, 4'h0, 1'b0);

    // table walk, one vector per cycle, back to back
    for (int i = 0; i < NV; i++) begin
      logic [85:0] v;
      v = VEC[i];
      drive(1'b1, v[81:78], v[77:76], v[75:74], v[73:69], v[68:37]);
      @(negedge clk);
      check_outputs(req_name(v[85:82]), 1'b1, v[36:5], v[4:1], v[0]);
    end

    // R10: idle input must not disturb the last result (byte store, be 0100)
    drive(1'b0, 4'd2, 2'd1, 2'd3, 5'd7, 32'h55AA55AA);
    @(negedge clk);
    check_outputs("R10", 1'b0, 32'hABABABAB, 4'h4, 1'b0);
    drive(1'b0, 4'd9, 2'd2, 2'd1, 5'd3, 32'h0F0F0F0F);
    @(negedge clk);
    check_outputs("R10", 1'b0, 32'hABABABAB, 4'h4, 1'b0);

    // R10: a single valid pulse gives a single valid output
    drive(1'b1, 4'd2, 2'd0, 2'd0, 5'd1, 32'h80000001);
    @(negedge clk);
    drive(1'b0, 4'd0, 2'd0, 2'd0, 5'd0, 32'h0);
    check_outputs("R10", 1'b1, 32'hC0000000, 4'h0, 1'b0);
    @(negedge clk);
    check_outputs("R10", 1'b0, 32'hC0000000, 4'h0, 1'b0);

    // R9 with R8: misaligned halfword store at offset 1
    drive(1'b1, 4'd8, 2'd1, 2'd1, 5'd0, 32'h0000BEEF);
    @(negedge clk);
    check_outputs("R9", 1'b1, 32'hBEEFBEEF, 4'h0, 1'b1);

    // R11: asynchronous reset in the middle of traffic
    drive(1'b1, 4'd8, 2'd2, 2'd0, 5'd0, 32'hCAFEF00D);
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1 check_outputs("R11", 1'b0, 32'h0, 4'h0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, 4'd0, 2'd0, 2'd0, 5'd0, 32'h0);
    repeat (3) @(negedge clk);
    drive(1'b1, 4'd1, 2'd0, 2'd0, 5'd16, 32'hCAFEF00D);
    @(negedge clk);
    check_outputs("R2", 1'b1, 32'h0000CAFE, 4'h0, 1'b0);
    drive(1'b0, 4'd0, 2'd0, 2'd0, 5'd0, 32'h0);
    @(negedge clk);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule